// File: doc/BRIEF.md
# Two-Level Address Translation Unit

This unit maps 32-bit virtual addresses to physical addresses for a processor's instruction-fetch path and data path, using 4 KB pages. Each path has a one-line first-level register that holds the most recent translation it used. When the incoming page number and the current address-space identifier match that line, the physical address is formed in the same cycle. A miss stalls the processor while a shared second-level table of 16 entries is searched. The table is organised as 4 rows of 4 ways, and one row is compared per cycle. A hit copies the matching entry into the first-level register of the path that missed. When no row matches, the unit raises a translation-miss exception and reports the faulting page number.

Privileged software fills the table with two write commands. One writes a chosen slot. The other writes the slot selected by a free-running counter. Translation is off after reset and after any trap, and software switches it on with an explicit enable pulse. While translation is off, the physical address equals the virtual address.

Top module: `tlb2_xlate`

## Requirements
- R1: After reset the unit is off (`mmu_on`=0). While it is off, each `*_pa` equals its `*_va`, and `stall` and `miss_exc` are low.
- R2: A pulse on `mmu_enable` sets `mmu_on` from the next cycle on. `trap` clears it from the next cycle on. `trap` takes precedence when both are high.
- R3: When the unit is on and a path's held line is valid with an equal page number (VA bits 31:12) and an equal `asid`, the path's PA is {held frame, VA[11:0]} in the same cycle, and that path does not stall.
- R4: On a miss, `stall` rises in the same cycle (cycle 0). Rows 0 to 3 are compared in cycles 1 to 4, one row per cycle. A hit in row r gives the correct translation, with `stall` low, in cycle r+2. Table slot s is row s/4, way s%4.
- R5: An entry matches only when it is valid, its page number is equal and its ASID is equal. If several entries match, the lowest row wins, and within that row the lowest way wins.
- R6: If no row matches, `stall` stays high for cycles 0 to 4. In cycle 5, `miss_exc` is high for exactly one cycle, `stall` is low, `mmu_on` is 0, and `fault_vpn` holds the missing page number.
- R7: A refill loads only the first-level line of the path that missed. The other path's line keeps its translation.
- R8: When both paths miss together, the instruction path is served first and the data path next. With both entries in row 0, `stall` is high for 4 cycles.
- R9: An indexed write (`wr_idx_en`) stores {valid, asid, vpn, pfn, flag} into slot `wr_index`.
- R10: A random write (`wr_rnd_en`) stores into the slot given by a 4-bit counter. The counter is 0 during reset and advances on every clock edge after reset is released. An indexed write takes precedence over a random write.
- R11: Any table write invalidates both first-level lines, so the next access searches the table again.
- R12: On a hit, `i_flag`/`d_flag` show the flag bit of the translating entry. They are 0 while the unit is off.
- R13: A trap during a search aborts it, with no refill and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_enable | input | 1 | Pulse that switches translation on |
| trap | input | 1 | Processor trap; switches translation off |
| asid | input | 6 | Current address-space identifier |
| i_req | input | 1 | Instruction fetch request |
| i_va | input | 32 | Instruction virtual address |
| d_req | input | 1 | Data access request |
| d_va | input | 32 | Data virtual address |
| wr_idx_en | input | 1 | Indexed table write command |
| wr_rnd_en | input | 1 | Random table write command |
| wr_index | input | 4 | Slot for indexed write |
| wr_vpn | input | 20 | Page number to write |
| wr_asid | input | 6 | ASID to write |
| wr_valid | input | 1 | Valid bit to write |
| wr_pfn | input | 20 | Frame number to write |
| wr_flag | input | 1 | Flag bit to write |
| mmu_on | output | 1 | Translation active |
| stall | output | 1 | Processor hold request |
| i_pa | output | 32 | Instruction physical address |
| i_flag | output | 1 | Flag of instruction translation |
| d_pa | output | 32 | Data physical address |
| d_flag | output | 1 | Flag of data translation |
| miss_exc | output | 1 | One-cycle translation-miss exception |
| fault_vpn | output | 20 | Page number that missed |

## Verification
A wrong row counter or slot composition shows up at the ports as a change in stall length. An entry written to slot s must take exactly s/4+2 stalled cycles to appear, so a per-slot sweep exposes any misplaced write or mis-ordered search within six cycles of the request. A stale or wrongly targeted first-level line shows up as a non-zero stall on a repeated access, or a zero stall where one is expected, on the very next request. A wrong random counter shifts the stall length of an entry written by a random write.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  localparam int VA_W   = 32;
  localparam int OFS_W  = 12;
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 6;
  localparam int ROWS   = 4;
  localparam int WAYS   = 4;
  localparam int SLOTS  = ROWS * WAYS;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SLOT_W = ROW_W + WAY_W;
  localparam int CNT_W  = ROW_W + 1;

  typedef struct packed {
    logic              valid;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
  } tag_t;

  // 1 + 6 + 20 + 20 + 1 = 48 bits per line
  typedef struct packed {
    tag_t             tag;
    logic [PFN_W-1:0] pfn;
    logic             flag;
  } line_t;

  function automatic logic tag_hit(tag_t t, logic [VPN_W-1:0] vpn,
                                   logic [ASID_W-1:0] id);
    return t.valid && (t.vpn == vpn) && (t.asid == id);
  endfunction

  function automatic logic [VA_W-1:0] phys_addr(logic [PFN_W-1:0] pfn,
                                                logic [VA_W-1:0] va);
    return {pfn, va[OFS_W-1:0]};
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(logic [ROW_W-1:0] r,
                                                logic [WAY_W-1:0] w);
    return {r, w};
  endfunction
endpackage

// File: rtl/tlb2_l1_line.sv
module tlb2_l1_line
  import tlb2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  line_t             fill,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic [PFN_W-1:0]  pfn,
  output logic              flag
);
  line_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (flush) held.tag.valid <= 1'b0;
    else if (load)  held <= fill;
  end

  assign hit  = tag_hit(held.tag, vpn, asid);
  assign pfn  = held.pfn;
  assign flag = held.flag;

  // R7: a refill that is not flushed leaves a valid line behind
  assert_refill_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> held.tag.valid);
endmodule

// File: rtl/tlb2_l2_table.sv
module tlb2_l2_table
  import tlb2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  line_t             wr_line,
  input  logic [ROW_W-1:0]  row,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic              hit,
  output line_t             rd_line
);
  line_t             store [SLOTS];
  logic [WAYS-1:0]   way_hit;
  logic [WAY_W-1:0]  hit_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) store[i] <= '0;
    end else if (wr_en) begin
      store[wr_slot] <= wr_line;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = tag_hit(store[slot_of(row, WAY_W'(w))].tag,
                                key_vpn, key_asid);
  end

  // lowest way wins
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (way_hit[w]) hit_way = WAY_W'(w);
  end

  assign hit     = |way_hit;
  assign rd_line = store[slot_of(row, hit_way)];
endmodule

// File: rtl/tlb2_walker.sv
module tlb2_walker
  import tlb2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmu_on,
  input  logic              trap,
  input  logic [1:0]        miss,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [VPN_W-1:0]  vpn_d,
  input  logic [ASID_W-1:0] asid,
  input  logic              l2_hit,
  output logic              busy,
  output logic [ROW_W-1:0]  row,
  output logic [VPN_W-1:0]  key_vpn,
  output logic [ASID_W-1:0] key_asid,
  output logic [1:0]        fill,
  output logic              exc_set,
  output logic              miss_exc,
  output logic [VPN_W-1:0]  fault_vpn
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROWS - 1);

  logic [CNT_W-1:0] cnt;
  logic             side;   // 0 instruction, 1 data
  logic             active;
  logic             start;

  assign row     = cnt[ROW_W-1:0];
  assign active  = busy && mmu_on && !trap;
  assign fill[0] = active && l2_hit && !side;
  assign fill[1] = active && l2_hit && side;
  assign exc_set = active && !l2_hit && (cnt == LAST);
  assign start   = mmu_on && !trap && !busy && (|miss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      side      <= 1'b0;
      key_vpn   <= '0;
      key_asid  <= '0;
      miss_exc  <= 1'b0;
      fault_vpn <= '0;
    end else begin
      miss_exc <= exc_set;
      if (exc_set) fault_vpn <= key_vpn;
      if (!mmu_on || trap) begin
        busy <= 1'b0;
      end else if (start) begin
        busy     <= 1'b1;
        cnt      <= '0;
        side     <= !miss[0];               // instruction path first
        key_vpn  <= miss[0] ? vpn_i : vpn_d;
        key_asid <= asid;
      end else if (busy) begin
        if (l2_hit || cnt == LAST) busy <= 1'b0;
        else                       cnt  <= cnt + 1'b1;
      end
    end
  end

  assert_row_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CNT_W'(ROWS)));

  assert_exc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_exc |=> !miss_exc);
endmodule

// File: rtl/tlb2_xlate.sv
module tlb2_xlate
  import tlb2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmu_enable,
  input  logic              trap,
  input  logic [ASID_W-1:0] asid,
  input  logic              i_req,
  input  logic [VA_W-1:0]   i_va,
  input  logic              d_req,
  input  logic [VA_W-1:0]   d_va,
  input  logic              wr_idx_en,
  input  logic              wr_rnd_en,
  input  logic [SLOT_W-1:0] wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_valid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_flag,
  output logic              mmu_on,
  output logic              stall,
  output logic [VA_W-1:0]   i_pa,
  output logic              i_flag,
  output logic [VA_W-1:0]   d_pa,
  output logic              d_flag,
  output logic              miss_exc,
  output logic [VPN_W-1:0]  fault_vpn
);
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rnd_ctr;
  line_t             wr_line;
  logic              busy;
  logic [ROW_W-1:0]  row;
  logic [VPN_W-1:0]  key_vpn;
  logic [ASID_W-1:0] key_asid;
  logic              l2_hit;
  line_t             l2_line;
  logic [1:0]        fill;
  logic              exc_set;

  logic [1:0]        req;
  logic [VA_W-1:0]   va   [2];
  logic [VA_W-1:0]   pa   [2];
  logic [1:0]        hit;
  logic [1:0]        miss;
  logic [PFN_W-1:0]  pfn  [2];
  logic [1:0]        flg;

  assign req   = {d_req, i_req};
  assign va[0] = i_va;
  assign va[1] = d_va;

  // free-running slot picker for random writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_ctr <= '0;
    else        rnd_ctr <= rnd_ctr + 1'b1;
  end

  assign wr_en   = wr_idx_en || wr_rnd_en;
  assign wr_slot = wr_idx_en ? wr_index : rnd_ctr;
  assign wr_line = '{tag: '{valid: wr_valid, asid: wr_asid, vpn: wr_vpn},
                     pfn: wr_pfn, flag: wr_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mmu_on <= 1'b0;
    else if (trap || exc_set)    mmu_on <= 1'b0;
    else if (mmu_enable)         mmu_on <= 1'b1;
  end

  for (genvar p = 0; p < 2; p++) begin : g_path
    tlb2_l1_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (wr_en),
      .load  (fill[p]),
      .fill  (l2_line),
      .vpn   (va[p][VA_W-1:OFS_W]),
      .asid  (asid),
      .hit   (hit[p]),
      .pfn   (pfn[p]),
      .flag  (flg[p])
    );
    assign miss[p] = req[p] && !hit[p];
    assign pa[p]   = mmu_on ? phys_addr(pfn[p], va[p]) : va[p];
  end

  tlb2_l2_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_line  (wr_line),
    .row      (row),
    .key_vpn  (key_vpn),
    .key_asid (key_asid),
    .hit      (l2_hit),
    .rd_line  (l2_line)
  );

  tlb2_walker u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mmu_on    (mmu_on),
    .trap      (trap),
    .miss      (miss),
    .vpn_i     (i_va[VA_W-1:OFS_W]),
    .vpn_d     (d_va[VA_W-1:OFS_W]),
    .asid      (asid),
    .l2_hit    (l2_hit),
    .busy      (busy),
    .row       (row),
    .key_vpn   (key_vpn),
    .key_asid  (key_asid),
    .fill      (fill),
    .exc_set   (exc_set),
    .miss_exc  (miss_exc),
    .fault_vpn (fault_vpn)
  );

  assign stall  = mmu_on && (busy || (|miss));
  assign i_pa   = pa[0];
  assign d_pa   = pa[1];
  assign i_flag = mmu_on && flg[0];
  assign d_flag = mmu_on && flg[1];

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_on |-> !stall);

  assert_trap_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !mmu_on);

  assert_exc_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_exc |-> (!stall && !mmu_on));
endmodule

// File: tb/tlb2_xlate_bench.sv
module tlb2_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmu_enable = 1'b0, trap = 1'b0;
  logic [5:0]  asid = 6'd1;
  logic        i_req = 1'b0, d_req = 1'b0;
  logic [31:0] i_va = '0, d_va = '0;
  logic        wr_idx_en = 1'b0, wr_rnd_en = 1'b0;
  logic [3:0]  wr_index = '0;
  logic [19:0] wr_vpn = '0;
  logic [5:0]  wr_asid = '0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_pfn = '0;
  logic        wr_flag = 1'b0;
  logic        mmu_on, stall, i_flag, d_flag, miss_exc;
  logic [31:0] i_pa, d_pa;
  logic [19:0] fault_vpn;

  int total = 0, bad = 0;
  logic [3:0] bctr;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bctr <= '0;
    else        bctr <= bctr + 1'b1;

  tlb2_xlate u_tlb2_xlate (
    .clk(clk), .rst_n(rst_n), .mmu_enable(mmu_enable), .trap(trap), .asid(asid),
    .i_req(i_req), .i_va(i_va), .d_req(d_req), .d_va(d_va),
    .wr_idx_en(wr_idx_en), .wr_rnd_en(wr_rnd_en), .wr_index(wr_index),
    .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_valid(wr_valid), .wr_pfn(wr_pfn),
    .wr_flag(wr_flag), .mmu_on(mmu_on), .stall(stall), .i_pa(i_pa),
    .i_flag(i_flag), .d_pa(d_pa), .d_flag(d_flag), .miss_exc(miss_exc),
    .fault_vpn(fault_vpn));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] pfn_of(input int k);
    return 20'h80000 + 20'(k * 7);
  endfunction

  task automatic wr(input bit rnd, input int idx, input logic [19:0] vpn,
                    input logic [5:0] id, input bit vld, input logic [19:0] pf,
                    input bit fl, output int used);
    @(negedge clk);
    wr_idx_en = !rnd; wr_rnd_en = rnd; wr_index = 4'(idx);
    wr_vpn = vpn; wr_asid = id; wr_valid = vld; wr_pfn = pf; wr_flag = fl;
    used = rnd ? int'(bctr) : idx;
    @(negedge clk);
    wr_idx_en = 1'b0; wr_rnd_en = 1'b0;
  endtask

  task automatic clear_all();
    int u;
    for (int s = 0; s < 16; s++) wr(1'b0, s, 20'h0, 6'd0, 1'b0, 20'h0, 1'b0, u);
  endtask

  task automatic turn_on();
    @(negedge clk); mmu_enable = 1'b1;
    @(negedge clk); mmu_enable = 1'b0;
  endtask

  // sel bit0 = instruction, bit1 = data; returns number of stalled cycles
  task automatic look(input bit [1:0] sel, input logic [31:0] iva, input logic [31:0] dva,
                      output int n, output bit exc);
    @(negedge clk);
    i_req = sel[0]; d_req = sel[1]; i_va = iva; d_va = dva;
    #1; n = 0;
    while (stall && n < 12) begin @(negedge clk); #1; n++; end
    exc = miss_exc;
  endtask

  task automatic idle();
    @(negedge clk); i_req = 1'b0; d_req = 1'b0;
  endtask

  initial begin : wd
    #(150000 * 5);
    check(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n, u, idx;
    bit ex;
    logic [31:0] va;
    repeat (3) @(negedge clk);
    i_req = 1'b1; i_va = 32'h1234_5678; d_req = 1'b1; d_va = 32'hCAFE_0123;
    #1;
    check(mmu_on == 1'b0, "R1 off in reset", mmu_on, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(mmu_on == 1'b0 && stall == 1'b0 && miss_exc == 1'b0, "R1 quiet after reset",
          {mmu_on, stall, miss_exc}, 0);
    check(i_pa == i_va, "R1 i identity", i_pa, i_va);
    check(d_pa == d_va, "R1 d identity", d_pa, d_va);
    check(i_flag == 1'b0, "R12 flag off", i_flag, 0);
    idle();

    // R2 enable timing and trap priority
    @(negedge clk); mmu_enable = 1'b1; #1;
    check(mmu_on == 1'b0, "R2 not yet on", mmu_on, 0);
    @(negedge clk); mmu_enable = 1'b0; #1;
    check(mmu_on == 1'b1, "R2 on next cycle", mmu_on, 1);
    @(negedge clk); mmu_enable = 1'b1; trap = 1'b1;
    @(negedge clk); mmu_enable = 1'b0; trap = 1'b0; #1;
    check(mmu_on == 1'b0, "R2 trap wins", mmu_on, 0);

    // R4 R9 R12 R3: per-slot sweep through indexed writes
    for (int k = 0; k < 16; k++) begin
      clear_all();
      wr(1'b0, k, 20'h40000 + 20'(k), 6'd1, 1'b1, pfn_of(k), k[0], u);
      turn_on();
      va = {20'h40000 + 20'(k), 12'(k * 37 + 5)};
      look(2'b01, va, 32'h0, n, ex);
      check(n == k / 4 + 2, "R4 R9 stall length per slot", n, k / 4 + 2);
      check(i_pa == {pfn_of(k), va[11:0]}, "R4 translated addr", i_pa, {pfn_of(k), va[11:0]});
      check(i_flag == k[0], "R12 flag of entry", i_flag, k[0]);
      idle();
      look(2'b01, va, 32'h0, n, ex);
      check(n == 0 && i_pa == {pfn_of(k), va[11:0]}, "R3 first-level hit", n, 0);
      idle();
    end

    // R10 random writes land at the counter slot
    for (int t = 0; t < 5; t++) begin
      clear_all();
      repeat (t * 3 + 1) @(negedge clk);
      wr(1'b1, 0, 20'h51111, 6'd1, 1'b1, 20'h0BEEF, 1'b0, idx);
      look(2'b01, 32'h5111_1ABC, 32'h0, n, ex);
      check(n == idx / 4 + 2, "R10 random slot row", n, idx / 4 + 2);
      check(i_pa == 32'h0BEE_FABC, "R10 random entry data", i_pa, 32'h0BEE_FABC);
      idle();
    end

    // R10 indexed wins over random
    clear_all();
    @(negedge clk);
    wr_idx_en = 1'b1; wr_rnd_en = 1'b1; wr_index = 4'd14; wr_vpn = 20'h62222;
    wr_asid = 6'd1; wr_valid = 1'b1; wr_pfn = 20'h01111; wr_flag = 1'b0;
    @(negedge clk); wr_idx_en = 1'b0; wr_rnd_en = 1'b0;
    look(2'b01, 32'h6222_2000, 32'h0, n, ex);
    check(n == 5, "R10 indexed precedence", n, 5);
    idle();

    // R5 duplicates: lowest way in a row, lowest row overall
    clear_all();
    wr(1'b0, 6, 20'h70000, 6'd1, 1'b1, 20'h00B0B, 1'b0, u);
    wr(1'b0, 5, 20'h70000, 6'd1, 1'b1, 20'h00A0A, 1'b0, u);
    look(2'b01, 32'h7000_0010, 32'h0, n, ex);
    check(n == 3 && i_pa == 32'h00A0_A010, "R5 lowest way", i_pa, 32'h00A0_A010);
    idle();
    clear_all();
    wr(1'b0, 9, 20'h70001, 6'd1, 1'b1, 20'h00C0C, 1'b0, u);
    wr(1'b0, 2, 20'h70001, 6'd1, 1'b1, 20'h00D0D, 1'b0, u);
    look(2'b01, 32'h7000_1020, 32'h0, n, ex);
    check(n == 2 && i_pa == 32'h00D0_D020, "R5 lowest row", i_pa, 32'h00D0_D020);
    idle();

    // R5 R6 ASID mismatch gives a miss exception
    clear_all();
    wr(1'b0, 3, 20'h33333, 6'd5, 1'b1, 20'h00123, 1'b0, u);
    asid = 6'd6;
    look(2'b01, 32'h3333_3444, 32'h0, n, ex);
    check(n == 5, "R6 stall through all rows", n, 5);
    check(ex == 1'b1, "R5 R6 asid mismatch exception", ex, 1);
    check(mmu_on == 1'b0 && fault_vpn == 20'h33333, "R6 off and fault vpn", fault_vpn, 20'h33333);
    @(negedge clk); #1;
    check(miss_exc == 1'b0, "R6 single pulse", miss_exc, 0);
    idle();
    asid = 6'd1;
    // R5 invalid entry never matches
    wr(1'b0, 4, 20'h44444, 6'd1, 1'b0, 20'h00999, 1'b0, u);
    turn_on();
    look(2'b10, 32'h0, 32'h4444_4000, n, ex);
    check(n == 5 && ex == 1'b1, "R5 invalid entry misses", n, 5);
    idle();

    // R8 both miss, instruction first
    clear_all();
    wr(1'b0, 0, 20'h10000, 6'd1, 1'b1, 20'h0AAAA, 1'b0, u);
    wr(1'b0, 1, 20'h20000, 6'd1, 1'b1, 20'h0BBBB, 1'b1, u);
    wr(1'b0, 12, 20'h30000, 6'd1, 1'b1, 20'h0CCCC, 1'b0, u);
    turn_on();
    look(2'b11, 32'h1000_0004, 32'h2000_0008, n, ex);
    check(n == 4, "R8 serial service length", n, 4);
    check(i_pa == 32'h0AAA_A004 && d_pa == 32'h0BBB_B008, "R8 both translated", d_pa, 32'h0BBB_B008);
    check(d_flag == 1'b1 && i_flag == 1'b0, "R12 per-path flag", {i_flag, d_flag}, 2'b01);
    idle();
    // R7 data refill leaves instruction line intact
    look(2'b10, 32'h0, 32'h3000_0FFC, n, ex);
    check(n == 5 && d_pa == 32'h0CCC_CFFC, "R7 data refill row 3", n, 5);
    idle();
    look(2'b01, 32'h1000_0100, 32'h0, n, ex);
    check(n == 0 && i_pa == 32'h0AAA_A100, "R7 instruction line kept", n, 0);
    idle();

    // R11 any write flushes both lines
    wr(1'b0, 15, 20'h99999, 6'd1, 1'b0, 20'h0, 1'b0, u);
    look(2'b01, 32'h1000_0100, 32'h0, n, ex);
    check(n == 2, "R11 instruction refetch after write", n, 2);
    idle();
    look(2'b10, 32'h0, 32'h3000_0000, n, ex);
    check(n == 5, "R11 data refetch after write", n, 5);
    idle();

    // R13 trap mid-search aborts
    clear_all();
    wr(1'b0, 13, 20'h55555, 6'd1, 1'b1, 20'h0DDDD, 1'b0, u);
    turn_on();
    @(negedge clk); i_req = 1'b1; i_va = 32'h5555_5000;
    @(negedge clk); @(negedge clk);
    trap = 1'b1;
    @(negedge clk); trap = 1'b0; #1;
    check(mmu_on == 1'b0 && stall == 1'b0, "R13 trap stops search", {mmu_on, stall}, 0);
    ex = 1'b0;
    for (int c = 0; c < 6; c++) begin @(negedge clk); #1; ex |= miss_exc; end
    check(ex == 1'b0, "R13 no exception after abort", ex, 0);
    idle();
    turn_on();
    look(2'b01, 32'h5555_5000, 32'h0, n, ex);
    check(n == 5, "R13 no refill happened", n, 5);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule